// File: doc/BRIEF.md
# Keyed Write Guard for a Register Window

This block sits between a simple register bus and a bank of configuration registers. It stops stray software writes from changing those registers. A control register holds a lock bit. While the lock bit is set, every write that falls inside a fixed byte-offset window is dropped before it reaches the register bank.

Each dropped write is logged in a status register. The log holds a sticky violation flag and the byte offset of the first write that was refused. The lock bit can be changed, and the log cleared, only by a control-register write that carries the expected key in its upper bits. A control write with any other key is discarded.

The block forwards the write enable toward the protected bank when a window write is allowed. It also returns its own two registers on the read-data bus.

Top module: `wp_guard`

## Requirements
- R1: After reset, the lock bit, the violation flag and the recorded offset are all zero. A read of the control register (offset 0x200) and a read of the status register (offset 0x204) both return 0.
- R2: While the lock bit is clear, a bus write to any offset from 0x000 to 0x1FC drives `reg_we` high in the same cycle, and the violation flag stays clear.
- R3: While the lock bit is set, a bus write to any offset from 0x000 to 0x1FC, including both ends, leaves `reg_we` low.
- R4: A refused write sets the violation flag (status bit 0), and the flag is visible from the cycle after the write.
- R5: When the flag is clear, a refused write stores its byte offset in status bits [19:8].
- R6: While the flag is set, further refused writes leave the stored offset and the flag unchanged.
- R7: A control-register write whose bits [31:8] equal the key 0x5AC3E1 does two things. It loads the lock bit from write-data bit 0, and it clears the violation flag. The control register reads back the lock bit in bit 0 and zeros in all other bits.
- R8: A control-register write whose bits [31:8] differ from the key changes neither the lock bit nor the flag.
- R9: Reading the status register does not change the flag or the stored offset.
- R10: A write to an offset outside 0x000 to 0x1FC never raises `reg_we` and never sets the flag. A write to the status register has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Read data for the control and status registers; zero elsewhere |
| reg_we | output | 1 | Write enable forwarded to the protected register bank |

## Verification
The forwarded `reg_we` is combinational, so it is due in the same cycle as the bus write. The bench samples it one time unit after it drives the inputs on the falling edge. The lock bit, the flag and the stored offset are registered, so they become visible on `bus_rdata` only after the rising edge that accepts the write. Each task therefore reads them back in the following low phase. Checks for ignored writes read back both registers after the stimulus and before the next write.

// File: rtl/wp_pkg.sv
package wp_pkg;
   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_WIN  = 2'd1,
      ACC_CTRL = 2'd2,
      ACC_STAT = 2'd3
   } acc_e;
endpackage

// File: rtl/wp_addr_decode.sv
module wp_addr_decode #(
   parameter int ADDR_W   = 12,
   parameter int WIN_LO   = 0,
   parameter int WIN_HI   = 'h1FC,
   parameter int CTRL_OFS = 'h200,
   parameter int STAT_OFS = 'h204
) (
   input  logic [ADDR_W-1:0] addr,
   output wp_pkg::acc_e      acc
);
   localparam logic [ADDR_W-1:0] LO_A   = ADDR_W'(WIN_LO);
   localparam logic [ADDR_W-1:0] HI_A   = ADDR_W'(WIN_HI);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

   logic lo_ok;
   logic hi_ok;

   // the lower compare is dropped when the window starts at zero
   generate
      if (WIN_LO == 0) begin : g_lo_zero
         assign lo_ok = 1'b1;
      end else begin : g_lo_cmp
         assign lo_ok = (addr >= LO_A);
      end
   endgenerate

   assign hi_ok = (addr <= HI_A);

   always_comb begin
      if (lo_ok && hi_ok)       acc = wp_pkg::ACC_WIN;
      else if (addr == CTRL_A)  acc = wp_pkg::ACC_CTRL;
      else if (addr == STAT_A)  acc = wp_pkg::ACC_STAT;
      else                      acc = wp_pkg::ACC_NONE;
   end
endmodule

// File: rtl/wp_ctrl_reg.sv
module wp_ctrl_reg #(
   parameter int          DATA_W = 32,
   parameter int          KEY_W  = 24,
   parameter logic [23:0] KEY    = 24'h5AC3E1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_wr,
   input  logic [DATA_W-1:0] wdata,
   output logic              lock,
   output logic              key_ok
);
   localparam logic [KEY_W-1:0] KEY_V = KEY_W'(KEY);

   // the key sits in the top KEY_W bits of the write data
   assign key_ok = ctrl_wr && (wdata[DATA_W-1 -: KEY_W] == KEY_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lock <= 1'b0;
      else if (key_ok) lock <= wdata[0];
   end
endmodule

// File: rtl/wp_viol_log.sv
module wp_viol_log #(
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              refused,
   input  logic [ADDR_W-1:0] addr,
   input  logic              clr,
   output logic              flag,
   output logic [ADDR_W-1:0] src
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
         src  <= '0;
      end else if (clr) begin
         flag <= 1'b0;
      end else if (refused && !flag) begin
         flag <= 1'b1;
         src  <= addr;
      end
   end
endmodule

// File: rtl/wp_guard.sv
module wp_guard #(
   parameter int          ADDR_W   = 12,
   parameter int          DATA_W   = 32,
   parameter int          WIN_LO   = 0,
   parameter int          WIN_HI   = 'h1FC,
   parameter int          CTRL_OFS = 'h200,
   parameter int          STAT_OFS = 'h204,
   parameter int          KEY_W    = 24,
   parameter logic [23:0] KEY      = 24'h5AC3E1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              reg_we
);
   localparam int SRC_LSB = 8;

   generate
      if (DATA_W < SRC_LSB + ADDR_W) begin : g_bad_dw
         $error("DATA_W too narrow for the offset field");
      end
      if (KEY_W + 1 > DATA_W || KEY_W > 24) begin : g_bad_kw
         $error("KEY_W does not fit");
      end
      if (WIN_HI >= CTRL_OFS && WIN_LO <= CTRL_OFS) begin : g_bad_ctrl
         $error("control register lies inside the guarded window");
      end
      if (WIN_HI >= STAT_OFS && WIN_LO <= STAT_OFS) begin : g_bad_stat
         $error("status register lies inside the guarded window");
      end
   endgenerate

   wp_pkg::acc_e      acc;
   logic              lock;
   logic              key_ok;
   logic              refused;
   logic              flag;
   logic [ADDR_W-1:0] src;

   wp_addr_decode #(
      .ADDR_W(ADDR_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI),
      .CTRL_OFS(CTRL_OFS), .STAT_OFS(STAT_OFS)
   ) u_dec (
      .addr (bus_addr),
      .acc  (acc)
   );

   wp_ctrl_reg #(.DATA_W(DATA_W), .KEY_W(KEY_W), .KEY(KEY)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctrl_wr (bus_we && acc == wp_pkg::ACC_CTRL),
      .wdata   (bus_wdata),
      .lock    (lock),
      .key_ok  (key_ok)
   );

   assign refused = bus_we && (acc == wp_pkg::ACC_WIN) && lock;
   assign reg_we  = bus_we && (acc == wp_pkg::ACC_WIN) && !lock;

   wp_viol_log #(.ADDR_W(ADDR_W)) u_log (
      .clk     (clk),
      .rst_n   (rst_n),
      .refused (refused),
      .addr    (bus_addr),
      .clr     (key_ok),
      .flag    (flag),
      .src     (src)
   );

   always_comb begin
      bus_rdata = '0;
      case (acc)
         wp_pkg::ACC_CTRL: bus_rdata[0] = lock;
         wp_pkg::ACC_STAT: begin
            bus_rdata[0]                     = flag;
            bus_rdata[SRC_LSB +: ADDR_W]     = src;
         end
         default: bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk #(
   parameter int          ADDR_W   = 12,
   parameter int          DATA_W   = 32,
   parameter int          WIN_LO   = 0,
   parameter int          WIN_HI   = 'h1FC,
   parameter int          CTRL_OFS = 'h200,
   parameter int          KEY_W    = 24,
   parameter logic [23:0] KEY      = 24'h5AC3E1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              reg_we,
   input logic              lock,
   input logic              flag,
   input logic [ADDR_W-1:0] src
);
   logic in_win;
   logic ctrl_wr;
   logic good_key;

   assign in_win   = (int'(bus_addr) >= WIN_LO) && (int'(bus_addr) <= WIN_HI);
   assign ctrl_wr  = bus_we && (int'(bus_addr) == CTRL_OFS);
   assign good_key = (bus_wdata[DATA_W-1 -: KEY_W] == KEY_W'(KEY));

   AST_PASS_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we && in_win && !lock |-> reg_we);                               // R2
   AST_NO_FLAG_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      !lock && !flag |=> !flag);                                           // R2
   AST_BLOCK_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we && in_win && lock |-> !reg_we);                               // R3
   AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we && in_win && lock |=> flag);                                  // R4
   AST_SRC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      flag && !(ctrl_wr && good_key) |=> flag && $stable(src));            // R6
   AST_CLEAR_ON_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr && good_key |=> !flag);                                      // R7
   AST_BAD_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr && !good_key && !(bus_we && in_win) |=> $stable(lock) && $stable(flag)); // R8
   AST_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_win |-> !reg_we);                                                // R10
endmodule

bind wp_guard wp_guard_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI),
   .CTRL_OFS(CTRL_OFS), .KEY_W(KEY_W), .KEY(KEY)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .reg_we    (reg_we),
   .lock      (lock),
   .flag      (flag),
   .src       (src)
);

// File: tb/test_wp_guard.sv
module test_wp_guard;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] GOOD = 32'h5AC3_E100;
   localparam logic [31:0] BAD  = 32'h5AC3_E000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        reg_we;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wp_guard i_wp_guard (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .reg_we    (reg_we)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // one write cycle; returns reg_we as seen during that cycle
   task automatic wr(input logic [11:0] a, input logic [31:0] d, output logic we_seen);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      #1 we_seen = reg_we;
      @(posedge clk);
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
   endtask

   function automatic logic [31:0] stat(input logic f, input logic [11:0] s);
      return {12'h0, s, 7'h0, f};
   endfunction

   task automatic t_reset();
      logic [31:0] d;
      rd(12'h200, d); check("R1 ctrl after reset", d, 32'h0);
      rd(12'h204, d); check("R1 status after reset", d, 32'h0);
   endtask

   task automatic t_unlocked();
      logic w; logic [31:0] d;
      wr(12'h000, 32'h1234, w); check("R2 pass at 0x000", {31'h0, w}, 32'h1);
      wr(12'h1FC, 32'h1234, w); check("R2 pass at 0x1FC", {31'h0, w}, 32'h1);
      rd(12'h204, d);           check("R2 no flag", d, 32'h0);
   endtask

   task automatic t_bad_key_lock();
      logic w; logic [31:0] d;
      wr(12'h200, BAD | 32'h1, w);
      rd(12'h200, d); check("R8 bad key no lock", d, 32'h0);
   endtask

   task automatic t_lock_and_block();
      logic w; logic [31:0] d;
      wr(12'h200, GOOD | 32'h1, w);
      rd(12'h200, d);           check("R7 lock set", d, 32'h1);
      wr(12'h1FC, 32'hFF, w);   check("R3 block at 0x1FC", {31'h0, w}, 32'h0);
      rd(12'h204, d);           check("R4 R5 flag and offset", d, stat(1'b1, 12'h1FC));
      wr(12'h000, 32'hFF, w);   check("R3 block at 0x000", {31'h0, w}, 32'h0);
      rd(12'h204, d);           check("R6 offset kept", d, stat(1'b1, 12'h1FC));
      rd(12'h204, d);           check("R9 reread unchanged", d, stat(1'b1, 12'h1FC));
   endtask

   task automatic t_outside();
      logic w; logic [31:0] d;
      wr(12'h208, 32'hFF, w);      check("R10 outside no reg_we", {31'h0, w}, 32'h0);
      wr(12'h204, 32'h0, w);
      rd(12'h204, d);              check("R10 status write ignored", d, stat(1'b1, 12'h1FC));
      wr(12'h200, BAD, w);
      rd(12'h204, d);              check("R8 bad key keeps flag", d, stat(1'b1, 12'h1FC));
      rd(12'h200, d);              check("R8 bad key keeps lock", d, 32'h1);
   endtask

   task automatic t_clear_and_relog();
      logic w; logic [31:0] d;
      wr(12'h200, GOOD | 32'h1, w);
      rd(12'h204, d);          check("R7 flag cleared", d[0] ? 32'h1 : 32'h0, 32'h0);
      rd(12'h200, d);          check("R7 lock kept", d, 32'h1);
      wr(12'h080, 32'h5, w);   check("R3 block at 0x080", {31'h0, w}, 32'h0);
      rd(12'h204, d);          check("R5 new offset", d, stat(1'b1, 12'h080));
      wr(12'h200, GOOD, w);
      rd(12'h200, d);          check("R7 unlock", d, 32'h0);
      rd(12'h204, d);          check("R7 flag cleared by unlock", d[0] ? 32'h1 : 32'h0, 32'h0);
      wr(12'h100, 32'h5, w);   check("R2 pass after unlock", {31'h0, w}, 32'h1);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      t_reset();
      t_unlocked();
      t_bad_key_lock();
      t_lock_and_block();
      t_outside();
      t_clear_and_relog();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule